// File: doc/BRIEF.md
# USB OTG Wrapper Register Decoder

This block is the bus-facing front end of an embedded USB OTG controller core. Byte, halfword and word accesses arrive on a simple request bus. The block decides where each one goes. Low addresses pass unchanged to the core's register port. A sparse mid-range window is folded onto a compact group of core offsets that covers the core's FIFO registers. Addresses from 0x400 upward reach a small local bank of wrapper registers: a constant revision, a masked system configuration with a soft-reset bit, a system status that always reports reset complete, an interface select, a simulation enable and a force-standby flag.

Rejected accesses raise one-cycle error pulses and change no register. These are writes to read-only registers, accesses to unmapped wrapper offsets and the unsupported simulation-enable write. The core's interrupt reaches a single output through one register stage. Read data, error pulses and register updates all appear one clock after the request. Core-port signals are driven combinationally in the cycle of the request.

Top module: `usb_otg_wrap_decoder`

## Requirements
- R1: A request with address below CORE_LIMIT (default 0x080) asserts core_req in the same cycle, with core_addr equal to the bus address and core_we, core_size and core_wdata copied from the bus.
- R2: A request with address from CORE_LIMIT to 0x3FF asserts core_req with core_addr = 0x20 + ((addr >> 3) & 0x3C). Requests at 0x400 and above never assert core_req.
- R3: A read returns its data on bus_rdata one cycle after the request. For core reads this is core_rdata as sampled in the request cycle. A word read at 0x400 returns the REV_VALUE parameter, and a word read at 0x408 always returns 1.
- R4: A word write at 0x404 stores wdata & 0x301F, which reads back from 0x404.
- R5: A write at 0x404 with bit 1 set first clears the interface select, force standby and simulation enable registers, then stores the masked value.
- R6: A word write at 0x40C keeps only bits [1:0]. A word write at 0x414 keeps only bit 0. Both read back from their own offsets.
- R7: A write at 0x400 or 0x408 pulses ro_err for exactly one cycle and leaves every register unchanged.
- R8: A wrapper-window access that is not a word access (size code 2), is not 4-byte aligned, or lies at offset 0x418 or higher pulses bad_err for one cycle and changes no register. Such a read returns 0.
- R9: A write at 0x410 pulses unsup_err for one cycle, and the register still reads 0.
- R10: irq_out equals core_irq delayed by one clock.
- R11: After hardware reset, bus_rdata, irq_out and all error pulses are 0, and configuration, interface select, simulation enable and force standby read 0.
- R12: Size codes are 0 for byte, 1 for halfword and 2 for word. At most one error pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| ro_err | output | 1 | Pulse: write to read-only register |
| bad_err | output | 1 | Pulse: unmapped wrapper access |
| unsup_err | output | 1 | Pulse: simulation-enable write |
| core_req | output | 1 | Core register port request |
| core_we | output | 1 | Core write enable |
| core_size | output | 2 | Core access width |
| core_addr | output | CORE_AW | Core register offset |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, same cycle as core_req |
| core_irq | input | 1 | Core interrupt level |
| irq_out | output | 1 | Registered interrupt output |

## Verification
Several properties are checked on every cycle. Low addresses pass through unchanged. Remapped core offsets stay word-aligned inside 0x20 to 0x5C. The error pulses never overlap. A rejected write leaves every wrapper register untouched, and the interrupt output lags its input by exactly one clock. Only the directed scenarios can show the stored values and the read data. These include the configuration mask, the order of soft reset followed by the store, the field truncation, the constant revision and status values, and the zero returned for unmapped reads.

// File: rtl/usbw_pkg.sv
package usbw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // Wrapper register selection; encoding follows word offset from 0x400.
  typedef enum logic [2:0] {
    WR_REV    = 3'd0,
    WR_SYSCFG = 3'd1,
    WR_SYSSTA = 3'd2,
    WR_IFSEL  = 3'd3,
    WR_SIMEN  = 3'd4,
    WR_STDBY  = 3'd5,
    WR_NONE   = 3'd6
  } wrap_sel_e;

  localparam int unsigned WRAP_BASE    = 32'h400;
  localparam int unsigned WRAP_SPAN    = 32'h18;
  localparam logic [31:0] SYSCFG_MASK  = 32'h0000_301F;
  localparam int unsigned SOFTRST_BIT  = 1;
  localparam logic [31:0] SYSSTA_VALUE = 32'h1;
  localparam int unsigned FOLD_BASE    = 32'h20;
  localparam int unsigned FOLD_MASK    = 32'h3C;
  localparam int unsigned FOLD_SHIFT   = 3;

endpackage

// File: rtl/usbw_addr_decode.sv
module usbw_addr_decode
  import usbw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CORE_AW    = 10,
  parameter int unsigned CORE_LIMIT = 32'h080
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  output logic               to_core,
  output logic [CORE_AW-1:0] core_addr,
  output wrap_sel_e          sel
);

  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(WRAP_BASE);
  localparam logic [ADDR_W-1:0] LIM_LO  = ADDR_W'(CORE_LIMIT);
  localparam logic [ADDR_W-1:0] SPAN_HI = ADDR_W'(WRAP_SPAN);

  logic [ADDR_W-1:0] wrap_off;
  logic [31:0]       folded;

  always_comb begin
    to_core  = (addr < WIN_LO);
    wrap_off = addr - WIN_LO;
    folded   = 32'(FOLD_BASE) + ((32'(addr) >> FOLD_SHIFT) & 32'(FOLD_MASK));

    if (addr < LIM_LO) core_addr = addr[CORE_AW-1:0];
    else               core_addr = folded[CORE_AW-1:0];

    sel = WR_NONE;
    if (!to_core && (wrap_off < SPAN_HI) && (wrap_off[1:0] == 2'b00) &&
        (size == SZ_WORD)) begin
      case (wrap_off[4:2])
        3'd0:    sel = WR_REV;
        3'd1:    sel = WR_SYSCFG;
        3'd2:    sel = WR_SYSSTA;
        3'd3:    sel = WR_IFSEL;
        3'd4:    sel = WR_SIMEN;
        3'd5:    sel = WR_STDBY;
        default: sel = WR_NONE;
      endcase
    end
  end

endmodule

// File: rtl/usbw_regbank.sv
module usbw_regbank
  import usbw_pkg::*;
#(
  parameter logic [31:0] REV_VALUE = 32'h0000_0040,
  parameter int unsigned IFSEL_W   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_we,
  input  wrap_sel_e   sel,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val,
  output logic        ro_err,
  output logic        bad_err,
  output logic        unsup_err
);

  logic [31:0]        syscfg_q, syscfg_d;
  logic [IFSEL_W-1:0] ifsel_q, ifsel_d;
  logic               stdby_q, stdby_d;
  logic               simen_q, simen_d;
  logic               ro_d, bad_d, unsup_d;

  always_comb begin
    syscfg_d = syscfg_q;
    ifsel_d  = ifsel_q;
    stdby_d  = stdby_q;
    simen_d  = simen_q;
    ro_d     = 1'b0;
    bad_d    = 1'b0;
    unsup_d  = 1'b0;
    if (acc_en) begin
      if (acc_we) begin
        case (sel)
          WR_REV, WR_SYSSTA: ro_d = 1'b1;
          WR_SYSCFG: begin
            if (wdata[SOFTRST_BIT]) begin
              ifsel_d = '0;
              stdby_d = 1'b0;
              simen_d = 1'b0;
            end
            syscfg_d = wdata & SYSCFG_MASK;
          end
          WR_IFSEL: ifsel_d = wdata[IFSEL_W-1:0];
          WR_SIMEN: unsup_d = 1'b1;
          WR_STDBY: stdby_d = wdata[0];
          default:  bad_d   = 1'b1;
        endcase
      end else if (sel == WR_NONE) begin
        bad_d = 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      WR_REV:    rd_val = REV_VALUE;
      WR_SYSCFG: rd_val = syscfg_q;
      WR_SYSSTA: rd_val = SYSSTA_VALUE;
      WR_IFSEL:  rd_val = 32'(ifsel_q);
      WR_SIMEN:  rd_val = 32'(simen_q);
      WR_STDBY:  rd_val = 32'(stdby_q);
      default:   rd_val = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syscfg_q  <= '0;
      ifsel_q   <= '0;
      stdby_q   <= 1'b0;
      simen_q   <= 1'b0;
      ro_err    <= 1'b0;
      bad_err   <= 1'b0;
      unsup_err <= 1'b0;
    end else begin
      syscfg_q  <= syscfg_d;
      ifsel_q   <= ifsel_d;
      stdby_q   <= stdby_d;
      simen_q   <= simen_d;
      ro_err    <= ro_d;
      bad_err   <= bad_d;
      unsup_err <= unsup_d;
    end
  end

  AST_RO_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    ro_err |-> ($stable(syscfg_q) && $stable(ifsel_q) && $stable(stdby_q) && $stable(simen_q))); // R7
  AST_BAD_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_err |-> ($stable(syscfg_q) && $stable(ifsel_q) && $stable(stdby_q) && $stable(simen_q))); // R8
  AST_UNSUP_KEEPS_SIMEN: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_err |-> ($stable(simen_q) && $stable(syscfg_q) && $stable(ifsel_q))); // R9
  AST_ONE_ERROR_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ro_err, bad_err, unsup_err})); // R12

endmodule

// File: rtl/usb_otg_wrap_decoder.sv
module usb_otg_wrap_decoder
  import usbw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CORE_AW    = 10,
  parameter int unsigned CORE_LIMIT = 32'h080,
  parameter logic [31:0] REV_VALUE  = 32'h0000_0040
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               ro_err,
  output logic               bad_err,
  output logic               unsup_err,
  output logic               core_req,
  output logic               core_we,
  output logic [1:0]         core_size,
  output logic [CORE_AW-1:0] core_addr,
  output logic [31:0]        core_wdata,
  input  logic [31:0]        core_rdata,
  input  logic               core_irq,
  output logic               irq_out
);

  localparam logic [ADDR_W-1:0] LIM_LO = ADDR_W'(CORE_LIMIT);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WRAP_BASE);

  logic              to_core;
  wrap_sel_e         sel;
  logic [31:0]       wrap_rd;
  logic              rd_fire;
  logic [31:0]       rdata_d;
  logic              irq_q;

  usbw_addr_decode #(
    .ADDR_W    (ADDR_W),
    .CORE_AW   (CORE_AW),
    .CORE_LIMIT(CORE_LIMIT)
  ) dec_i (
    .addr     (bus_addr),
    .size     (bus_size),
    .to_core  (to_core),
    .core_addr(core_addr),
    .sel      (sel)
  );

  usbw_regbank #(
    .REV_VALUE(REV_VALUE),
    .IFSEL_W  (2)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (bus_req && !to_core),
    .acc_we   (bus_we),
    .sel      (sel),
    .wdata    (bus_wdata),
    .rd_val   (wrap_rd),
    .ro_err   (ro_err),
    .bad_err  (bad_err),
    .unsup_err(unsup_err)
  );

  assign core_req   = bus_req && to_core;
  assign core_we    = bus_we;
  assign core_size  = bus_size;
  assign core_wdata = bus_wdata;

  always_comb begin
    rd_fire = bus_req && !bus_we;
    rdata_d = bus_rdata;
    if (rd_fire) rdata_d = to_core ? core_rdata : wrap_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      irq_q     <= core_irq;
    end
  end

  assign irq_out = irq_q;

  AST_LOW_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr < LIM_LO) |-> (core_req && core_addr == CORE_AW'(bus_addr))); // R1
  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && bus_addr >= LIM_LO) |->
      (core_addr >= CORE_AW'(32'h20) && core_addr <= CORE_AW'(32'h5C) && core_addr[1:0] == 2'b00)); // R2
  AST_WRAP_NOT_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr >= WIN_LO) |-> !core_req); // R2
  AST_IRQ_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == $past(core_irq))); // R10

endmodule

// File: tb/usb_otg_wrap_decoder_tb.sv
module usb_otg_wrap_decoder_tb_top;

  localparam int unsigned AW  = 12;
  localparam int unsigned CAW = 10;
  localparam logic [31:0] REV = 32'h0000_0040;

  logic           clk, rst_n;
  logic           bus_req, bus_we;
  logic [1:0]     bus_size;
  logic [AW-1:0]  bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic           ro_err, bad_err, unsup_err;
  logic           core_req, core_we;
  logic [1:0]     core_size;
  logic [CAW-1:0] core_addr;
  logic [31:0]    core_wdata, core_rdata;
  logic           core_irq, irq_out;

  int n_chk = 0;
  int n_bad = 0;

  // Simple core model: read data encodes the offset it was asked for.
  assign core_rdata = 32'hC0DE_0000 | 32'(core_addr);

  usb_otg_wrap_decoder #(.ADDR_W(AW), .CORE_AW(CAW), .CORE_LIMIT(32'h080), .REV_VALUE(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ro_err(ro_err), .bad_err(bad_err), .unsup_err(unsup_err),
    .core_req(core_req), .core_we(core_we), .core_size(core_size), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_irq(core_irq), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  // One access; returns read data and the error pulses seen one cycle later.
  task automatic access(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output logic [2:0] errs);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    rd = bus_rdata; errs = {ro_err, bad_err, unsup_err};
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_word(input logic [AW-1:0] a, output logic [31:0] rd);
    logic [2:0] e;
    access(1'b0, 2'd2, a, 32'h0, rd, e);
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] wd, output logic [2:0] e);
    logic [31:0] r;
    access(1'b1, 2'd2, a, wd, r, e);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk(bus_rdata == 0 && irq_out == 0 && {ro_err, bad_err, unsup_err} == 0, "R11 outputs", bus_rdata, 0);
    rd_word(12'h404, r); chk(r == 0, "R11 syscfg", r, 0);
    rd_word(12'h40C, r); chk(r == 0, "R11 ifsel", r, 0);
    rd_word(12'h410, r); chk(r == 0, "R11 simen", r, 0);
    rd_word(12'h414, r); chk(r == 0, "R11 stdby", r, 0);
  endtask

  task automatic t_low_pass();
    logic [31:0] r; logic [2:0] e;
    logic [AW-1:0] addrs [3] = '{12'h000, 12'h04D, 12'h07C};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_size = 2'(i); bus_addr = addrs[i]; bus_wdata = 32'h1234_5600 + i;
      #1;
      chk(core_req && core_we && core_size == 2'(i) && core_addr == CAW'(addrs[i]) &&
          core_wdata == 32'h1234_5600 + i, "R1 passthrough", 32'(core_addr), 32'(addrs[i]));
      bus_req = 0; bus_we = 0;
    end
    access(1'b0, 2'd1, 12'h044, 0, r, e);
    chk(r == (32'hC0DE_0000 | 32'h044), "R3 core read data", r, 32'hC0DE_0044);
  endtask

  task automatic t_remap();
    logic [AW-1:0] addrs [4] = '{12'h080, 12'h1F8, 12'h200, 12'h3FF};
    logic [31:0] r; logic [2:0] e;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] exp;
      exp = 32'h20 + ((32'(addrs[i]) >> 3) & 32'h3C);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_size = 2'd0; bus_addr = addrs[i];
      #1;
      chk(core_req && core_size == 2'd0 && 32'(core_addr) == exp, "R2 fold", 32'(core_addr), exp);
      @(negedge clk);
      chk(bus_rdata == (32'hC0DE_0000 | exp), "R3 folded read", bus_rdata, 32'hC0DE_0000 | exp);
      bus_req = 0;
    end
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_size = 2'd2; bus_addr = 12'h40C; #1;
    chk(!core_req, "R2 wrapper not to core", 32'(core_req), 0);
    bus_req = 0; bus_we = 0;
    access(1'b0, 2'd2, 12'h408, 0, r, e);
  endtask

  task automatic t_consts();
    logic [31:0] r;
    rd_word(12'h400, r); chk(r == REV, "R3 revision", r, REV);
    rd_word(12'h408, r); chk(r == 1, "R3 sysstatus", r, 1);
  endtask

  task automatic t_fields();
    logic [31:0] r; logic [2:0] e;
    wr_word(12'h404, 32'hFFFF_FFFD, e); rd_word(12'h404, r);
    chk(r == 32'h301D, "R4 syscfg mask", r, 32'h301D);
    wr_word(12'h40C, 32'hFFFF_FFFE, e); rd_word(12'h40C, r);
    chk(r == 2, "R6 ifsel bits", r, 2);
    wr_word(12'h414, 32'hFFFF_FFFF, e); rd_word(12'h414, r);
    chk(r == 1, "R6 stdby bit", r, 1);
  endtask

  task automatic t_softreset();
    logic [31:0] r; logic [2:0] e;
    wr_word(12'h40C, 32'h3, e); wr_word(12'h414, 32'h1, e);
    wr_word(12'h404, 32'hF000_1006, e);
    rd_word(12'h404, r); chk(r == 32'h1006, "R5 store after soft reset", r, 32'h1006);
    rd_word(12'h40C, r); chk(r == 0, "R5 ifsel cleared", r, 0);
    rd_word(12'h414, r); chk(r == 0, "R5 stdby cleared", r, 0);
  endtask

  task automatic t_readonly();
    logic [31:0] r; logic [2:0] e;
    wr_word(12'h40C, 32'h1, e);
    wr_word(12'h400, 32'hFFFF_FFFF, e); chk(e == 3'b100, "R7 ro pulse rev", 32'(e), 32'b100);
    @(negedge clk); chk(ro_err == 0, "R7 single pulse", 32'(ro_err), 0);
    wr_word(12'h408, 32'h0, e); chk(e == 3'b100, "R7 ro pulse sysstatus", 32'(e), 32'b100);
    rd_word(12'h400, r); chk(r == REV, "R7 rev unchanged", r, REV);
    rd_word(12'h40C, r); chk(r == 1, "R7 ifsel unchanged", r, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] r; logic [2:0] e;
    access(1'b0, 2'd2, 12'h418, 0, r, e);
    chk(e == 3'b010 && r == 0, "R8 unmapped read", r, 0);
    access(1'b1, 2'd0, 12'h40C, 32'h2, r, e);
    chk(e == 3'b010, "R8 byte write to wrapper", 32'(e), 32'b010);
    access(1'b1, 2'd2, 12'h40E, 32'h3, r, e);
    chk(e == 3'b010, "R8 misaligned write", 32'(e), 32'b010);
    rd_word(12'h40C, r); chk(r == 1, "R8 ifsel unchanged", r, 1);
  endtask

  task automatic t_unsup();
    logic [31:0] r; logic [2:0] e;
    wr_word(12'h410, 32'h1, e); chk(e == 3'b001, "R9 unsup pulse", 32'(e), 32'b001);
    rd_word(12'h410, r); chk(r == 0, "R9 simen stays 0", r, 0);
  endtask

  task automatic t_irq();
    @(negedge clk); core_irq = 1; #1;
    chk(irq_out == 0, "R10 not yet", 32'(irq_out), 0);
    @(negedge clk); chk(irq_out == 1, "R10 rise", 32'(irq_out), 1);
    core_irq = 0;
    @(negedge clk); chk(irq_out == 0, "R10 fall", 32'(irq_out), 0);
  endtask

  initial begin
    bus_req = 0; bus_we = 0; bus_size = 0; bus_addr = '0; bus_wdata = '0; core_irq = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_low_pass();
    t_remap();
    t_consts();
    t_fields();
    t_softreset();
    t_readonly();
    t_unmapped();
    t_unsup();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0x%08h exp=0x%08h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule